// File: doc/BRIEF.md
# Shift-Register LIFO Stack

A four-entry last-in-first-out store held in a chain of registers instead of a memory with a pointer. On each rising clock edge the block does exactly one thing: it takes in a word, gives back a word, or keeps its state. Taking in a word shifts every stored word one slot deeper and writes the new word into the top slot. Giving back a word shifts every stored word one slot toward the top and loads zero into the deepest slot.

The top slot drives the data output at all times, so the current top word can be read without any read strobe. A small occupancy counter, from zero to the depth, drives the empty and full flags. If both strobes are high in the same cycle, only the pop takes place. A push into a full stack drops the deepest word. A pop from an empty stack does nothing. The data width is a parameter with a default of 8 bits.

Top module: `lifo_shift_stack`

## Requirements
- R1: After a synchronous active-high reset, `empty` is 1, `full` is 0 and `dout` is 0.
- R2: A push with pop low makes `dout` equal the pushed word after that clock edge, with no read strobe needed.
- R3: When push and pop are both high, only the pop is performed and the incoming word is not stored.
- R4: Pops return the stored words in the reverse of the order in which they were pushed.
- R5: The stack holds four words. `full` is 1 exactly when four words are held, and `empty` is 1 exactly when none are held.
- R6: A push while full stores the new word on top, drops the deepest word, and leaves the count at four.
- R7: A pop while empty changes nothing: `dout` and the flags keep their values.
- R8: A pop loads zero into the deepest slot, so `dout` reads 0 whenever the stack is empty.
- R9: A cycle with both strobes low leaves every stored word and the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| push | input | 1 | Store `din` on top of the stack |
| pop | input | 1 | Remove the top word; takes priority over `push` |
| din | input | WIDTH | Word to push |
| dout | output | WIDTH | Current top-of-stack word |
| empty | output | 1 | No words are held |
| full | output | 1 | Four words are held |

## Verification
Directed sequences fill the stack with known words, overfill it, and then drain it. This shows both the reverse ordering and which word a push into a full stack drops. Separate directed sequences pop an empty stack, assert both strobes together, and idle. Each one separates the correct behaviour from a plausible wrong one: wrapping or underflowing the count, letting push win, or drifting while idle. A long run of random operations with a fixed seed, weighted toward the full and empty edges, is then compared after every cycle against a reference model that tracks the contents and the count.

// File: rtl/lifo_pkg.sv
package lifo_pkg;
    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_PUSH = 2'd1,
        OP_POP  = 2'd2
    } stack_op_e;
endpackage

// File: rtl/lifo_slot.sv
module lifo_slot
    import lifo_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  stack_op_e        op,
    input  logic [WIDTH-1:0] shallow_i,
    input  logic [WIDTH-1:0] deep_i,
    output logic [WIDTH-1:0] word_o
);
    typedef struct packed {
        logic [WIDTH-1:0] word;
    } slot_t;

    slot_t slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        case (op)
            OP_PUSH: slot_d.word = shallow_i;
            OP_POP:  slot_d.word = deep_i;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) slot_q <= '0;
        else     slot_q <= slot_d;
    end

    assign word_o = slot_q.word;

    // R9: an idle cycle leaves this slot untouched
    assert_idle_stable_R9: assert property (@(posedge clk) disable iff (rst)
        (op == OP_HOLD) |=> (word_o == $past(word_o)));
endmodule

// File: rtl/lifo_level.sv
module lifo_level
    import lifo_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  stack_op_e op,
    output logic      empty,
    output logic      full
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] TOP_COUNT = CW'(DEPTH);

    typedef struct packed {
        logic [CW-1:0] count;
    } level_t;

    level_t lvl_d, lvl_q;

    always_comb begin
        lvl_d = lvl_q;
        case (op)
            OP_PUSH: if (lvl_q.count != TOP_COUNT) lvl_d.count = lvl_q.count + 1'b1;
            OP_POP:  lvl_d.count = lvl_q.count - 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) lvl_q <= '0;
        else     lvl_q <= lvl_d;
    end

    assign empty = (lvl_q.count == '0);
    assign full  = (lvl_q.count == TOP_COUNT);

    assert_count_bound_R5: assert property (@(posedge clk) disable iff (rst)
        lvl_q.count <= TOP_COUNT);
    assert_pop_drops_one_R4: assert property (@(posedge clk) disable iff (rst)
        (op == OP_POP) |=> (lvl_q.count == $past(lvl_q.count) - 1'b1));
    assert_full_push_holds_R6: assert property (@(posedge clk) disable iff (rst)
        (op == OP_PUSH && full) |=> full);
endmodule

// File: rtl/lifo_shift_stack.sv
module lifo_shift_stack
    import lifo_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic             pop,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout,
    output logic             empty,
    output logic             full
);
    stack_op_e        op;
    logic [WIDTH-1:0] words [DEPTH];

    // pop wins; a pop on an empty stack becomes a hold
    always_comb begin
        if (pop)       op = empty ? OP_HOLD : OP_POP;
        else if (push) op = OP_PUSH;
        else           op = OP_HOLD;
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic [WIDTH-1:0] shallow, deep;
        if (i == 0) begin : g_top
            assign shallow = din;
        end else begin : g_inner_s
            assign shallow = words[i-1];
        end
        if (i == DEPTH - 1) begin : g_bottom
            assign deep = '0;
        end else begin : g_inner_d
            assign deep = words[i+1];
        end
        lifo_slot #(.WIDTH(WIDTH)) u_slot (
            .clk(clk), .rst(rst), .op(op),
            .shallow_i(shallow), .deep_i(deep), .word_o(words[i])
        );
    end

    lifo_level #(.DEPTH(DEPTH)) u_level (
        .clk(clk), .rst(rst), .op(op), .empty(empty), .full(full)
    );

    assign dout = words[0];

    assert_push_shows_R2: assert property (@(posedge clk) disable iff (rst)
        (push && !pop) |=> (dout == $past(din)));
    assert_pop_wins_R3: assert property (@(posedge clk) disable iff (rst)
        (push && pop && !empty) |=> (dout == $past(words[1])));
    assert_empty_pop_R7: assert property (@(posedge clk) disable iff (rst)
        (pop && empty) |=> (empty && dout == $past(dout)));
    assert_empty_zero_R8: assert property (@(posedge clk) disable iff (rst)
        empty |-> (dout == '0));
endmodule

// File: tb/sim_lifo_shift_stack.sv
module sim_lifo_shift_stack;
    localparam int W = 8;
    localparam int D = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic push = 1'b0, pop = 1'b0;
    logic [W-1:0] din = '0;
    logic [W-1:0] dout;
    logic empty, full;

    int total = 0, bad = 0;
    bit finished = 0;
    logic [W-1:0] m [D];
    int mc = 0;

    always #2.5 clk = ~clk;

    lifo_shift_stack #(.WIDTH(W), .DEPTH(D)) u0 (
        .clk(clk), .rst(rst), .push(push), .pop(pop),
        .din(din), .dout(dout), .empty(empty), .full(full)
    );

    function automatic void model_step(bit pu, bit po, logic [W-1:0] d);
        if (po) begin
            if (mc > 0) begin
                for (int i = 0; i < D - 1; i++) m[i] = m[i+1];
                m[D-1] = '0;
                mc--;
            end
        end else if (pu) begin
            for (int i = D - 1; i > 0; i--) m[i] = m[i-1];
            m[0] = d;
            if (mc < D) mc++;
        end
    endfunction

    task automatic check(string req);
        total++;
        if (dout !== m[0] || empty !== (mc == 0) || full !== (mc == D)) begin
            bad++;
            $display("FAIL %s: dout=%h empty=%b full=%b expected dout=%h empty=%b full=%b",
                     req, dout, empty, full, m[0], mc == 0, mc == D);
        end
    endtask

    task automatic step(bit pu, bit po, logic [W-1:0] d, string req);
        @(negedge clk);
        push = pu; pop = po; din = d;
        model_step(pu, po, d);
        @(posedge clk);
        #1;
        check(req);
    endtask

    initial begin
        for (int i = 0; i < D; i++) m[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        #1 check("R1 reset state");
        // R5: fill with four words
        step(1, 0, 8'h11, "R2 push top");
        step(1, 0, 8'h22, "R2 push top");
        step(1, 0, 8'h33, "R2 push top");
        step(1, 0, 8'h44, "R5 full after four");
        // R6: overfill drops deepest (0x11)
        step(1, 0, 8'h55, "R6 push while full");
        // R9: idle
        step(0, 0, 8'hAA, "R9 idle");
        // R4/R6: drain in reverse, 0x11 gone
        step(0, 1, 8'h00, "R4 pop order");
        step(0, 1, 8'h00, "R4 pop order");
        step(0, 1, 8'h00, "R6 deepest dropped");
        step(0, 1, 8'h00, "R8 empty reads zero");
        // R7: pop when empty
        step(0, 1, 8'h00, "R7 pop while empty");
        step(1, 1, 8'h77, "R7 both strobes while empty");
        // R3: both strobes with content
        step(1, 0, 8'h66, "R2 push top");
        step(1, 0, 8'h67, "R2 push top");
        step(1, 1, 8'h99, "R3 pop wins");
        step(0, 1, 8'h00, "R3 word not stored");
        step(0, 0, 8'h00, "R9 idle empty");
        // random mix
        void'($urandom(32'd2024));
        for (int n = 0; n < 3000; n++) begin
            int r;
            bit pu, po;
            string req;
            r = $urandom_range(0, 9);
            pu = (r < 5) || (r == 8);
            po = (r >= 5 && r <= 8);
            if (po && pu)       req = "R3 random both";
            else if (po)        req = (mc == 0) ? "R7 random pop empty" : "R4 random pop";
            else if (pu)        req = (mc == D) ? "R6 random push full" : "R2 random push";
            else                req = "R9 random idle";
            step(pu, po, W'($urandom), req);
        end
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #100000;
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule